// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a successive-approximation analog-to-digital converter. It runs from the bus clock. An internal prescaler derives a slower conversion clock from a 5-bit divide value. When a start pulse arrives, the block first holds the sample-enable output high for a two-stage acquisition window. The first stage is fixed; the second is chosen from four lengths. It then searches for the digital code one bit per conversion clock. At each step it drives a trial code to an external DAC and reads back a one-bit comparator decision.

The result is either 10 or 8 bits wide and is returned right-aligned. A one-cycle done pulse marks it. An abort pulse, which stands for a control-register write in the surrounding system, drops any conversion in progress. The timing and resolution settings are captured when the conversion starts.

Top module: `sar_conv_ctrl`

## Requirements
- R1: The conversion clock ticks once every 2*(prs_i+1) bus clocks, counted from the cycle after an accepted start. A conversion with S sample ticks and N bits ends with done_o high exactly (S+N)*2*(prs_i+1) bus clocks after the start edge.
- R2: sample_o is high for the first S = 2 + (2 << smp_sel_i) conversion ticks of a conversion: 2 fixed ticks, then 2, 4, 8 or 16 ticks for smp_sel_i = 0..3. It is low at all other times.
- R3: The trial code is cleared at start. dac_code_o is zero while idle and during the sample window.
- R4: At search step j (0 = first), dac_code_o holds the bits already decided above position N-1-j, a 1 at position N-1-j, and zeros below it. In 8-bit mode the code is shifted left by two so that it spans the DAC's 10-bit scale.
- R5: At the end of each step the trial bit is cleared if cmp_i is 1 (DAC above input) and kept if cmp_i is 0. With an ideal comparator, the result is the largest code whose DAC value does not exceed the input.
- R6: res8_i = 0 selects a 10-bit result in result_o[9:0]. res8_i = 1 selects an 8-bit result in result_o[7:0], with result_o[9:8] zero.
- R7: done_o is a single-cycle pulse. result_o takes the new code in that same cycle and keeps it until the next done pulse. It is zero after reset.
- R8: busy_o rises the cycle after an accepted start and falls in the done cycle. The done cycle itself has busy_o low.
- R9: An abort_i pulse returns the block to idle by the next cycle, with busy_o low and no done pulse. result_o is unchanged. An abort in the same cycle as a start wins over it.
- R10: A start pulse received while busy_o is high is ignored and does not alter the timing or result of the running conversion.
- R11: res8_i, smp_sel_i and prs_i are captured at start. Later changes do not affect the running conversion.
- R12: cmp_i is ignored outside the search phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| abort_i | input | 1 | Abort pulse (control write) |
| res8_i | input | 1 | 1 = 8-bit, 0 = 10-bit resolution |
| smp_sel_i | input | 2 | Second sample stage length select |
| prs_i | input | 5 | Prescaler value |
| cmp_i | input | 1 | Comparator: 1 when DAC output exceeds input |
| dac_code_o | output | 10 | Trial code to the DAC |
| sample_o | output | 1 | Sample-and-hold enable |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 10 | Last completed result, right-aligned |

## Verification
The assertions check several rules on every clock:
- done is a single pulse and never overlaps busy;
- sample implies busy;
- the DAC code is quiet outside the search;
- the result stays stable between done pulses;
- an abort leaves the block idle.

Only the bench's scenarios can show the rest. These are the exact tick timing for each prescaler and sample select, the bit-by-bit trial codes and final codes for chosen inputs in both resolutions, and that a second start, a mid-conversion settings change or comparator noise during sampling leaves the outcome untouched. A behavioural model predicts busy, sample, done, trial code and result for every cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SMP_A  = 2'd1,
        ST_SMP_B  = 2'd2,
        ST_SEARCH = 2'd3
    } sar_state_e;

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
    parameter int PRS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [PRS_W-1:0] prs_i,
    output logic             tick_o
);
    localparam int CW = PRS_W + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t          pre_d, pre_q;
    logic [CW-1:0] limit;
    logic          tick;

    always_comb begin
        pre_d = pre_q;
        limit = {prs_i, 1'b1};
        tick  = 1'b0;
        if (clr_i || !run_i) begin
            pre_d.cnt = '0;
        end else if (pre_q.cnt == limit) begin
            tick      = 1'b1;
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick_o = tick;
endmodule

// File: rtl/sar_search.sv
module sar_search #(
    parameter int MAX_BITS = 10,
    parameter int LOW_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                seed_i,
    input  logic                step_i,
    input  logic                res8_i,
    input  logic                cmp_i,
    output logic [MAX_BITS-1:0] code_o,
    output logic [MAX_BITS-1:0] decided_o,
    output logic                last_o
);
    localparam logic [MAX_BITS-1:0] HI_MSB = MAX_BITS'(1) << (MAX_BITS - 1);
    localparam logic [MAX_BITS-1:0] LO_MSB = MAX_BITS'(1) << (LOW_BITS - 1);

    typedef struct packed {
        logic [MAX_BITS-1:0] sar;
        logic [MAX_BITS-1:0] mask;
    } srch_t;

    srch_t               s_d, s_q;
    logic [MAX_BITS-1:0] decided;

    always_comb begin
        s_d     = s_q;
        decided = cmp_i ? (s_q.sar & ~s_q.mask) : s_q.sar;
        if (clr_i) begin
            s_d.sar  = '0;
            s_d.mask = '0;
        end else if (seed_i) begin
            s_d.mask = res8_i ? LO_MSB : HI_MSB;
            s_d.sar  = res8_i ? LO_MSB : HI_MSB;
        end else if (step_i) begin
            s_d.mask = s_q.mask >> 1;
            s_d.sar  = decided | (s_q.mask >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign code_o    = s_q.sar;
    assign decided_o = decided;
    assign last_o    = s_q.mask[0];
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int MAX_BITS    = 10,
    parameter int LOW_BITS    = 8,
    parameter int PRS_W       = 5,
    parameter int SMP_W       = 2,
    parameter int FIRST_TICKS = 2,
    parameter int SECOND_BASE = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                abort_i,
    input  logic                res8_i,
    input  logic [SMP_W-1:0]    smp_sel_i,
    input  logic [PRS_W-1:0]    prs_i,
    input  logic                cmp_i,
    output logic [MAX_BITS-1:0] dac_code_o,
    output logic                sample_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [MAX_BITS-1:0] result_o
);
    localparam int SMP_MAX = SECOND_BASE << ((1 << SMP_W) - 1);
    localparam int LEN_MAX = (SMP_MAX > FIRST_TICKS) ? SMP_MAX : FIRST_TICKS;
    localparam int TCW     = $clog2(LEN_MAX + 1);
    localparam int SHIFT   = MAX_BITS - LOW_BITS;

    typedef struct packed {
        sar_state_e          st;
        logic [TCW-1:0]      tcnt;
        logic                res8;
        logic [SMP_W-1:0]    sel;
        logic [PRS_W-1:0]    prs;
        logic                done;
        logic [MAX_BITS-1:0] result;
    } ctrl_t;

    ctrl_t               c_d, c_q;
    logic                tick;
    logic                start_ok;
    logic                seed;
    logic                step;
    logic [TCW-1:0]      stage2_last;
    logic [MAX_BITS-1:0] code;
    logic [MAX_BITS-1:0] decided;
    logic                last_bit;

    sar_prescaler #(.PRS_W(PRS_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_ok || abort_i),
        .run_i  (c_q.st != ST_IDLE),
        .prs_i  (c_q.prs),
        .tick_o (tick)
    );

    sar_search #(.MAX_BITS(MAX_BITS), .LOW_BITS(LOW_BITS)) u_srch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (start_ok),
        .seed_i    (seed),
        .step_i    (step),
        .res8_i    (c_q.res8),
        .cmp_i     (cmp_i),
        .code_o    (code),
        .decided_o (decided),
        .last_o    (last_bit)
    );

    always_comb begin
        c_d         = c_q;
        c_d.done    = 1'b0;
        start_ok    = start_i && !abort_i && (c_q.st == ST_IDLE);
        seed        = 1'b0;
        step        = 1'b0;
        stage2_last = TCW'((SECOND_BASE << c_q.sel) - 1);
        if (abort_i) begin
            c_d.st   = ST_IDLE;
            c_d.tcnt = '0;
        end else begin
            case (c_q.st)
                ST_IDLE: begin
                    if (start_ok) begin
                        c_d.st   = ST_SMP_A;
                        c_d.tcnt = '0;
                        c_d.res8 = res8_i;
                        c_d.sel  = smp_sel_i;
                        c_d.prs  = prs_i;
                    end
                end
                ST_SMP_A: begin
                    if (tick) begin
                        if (c_q.tcnt == TCW'(FIRST_TICKS - 1)) begin
                            c_d.st   = ST_SMP_B;
                            c_d.tcnt = '0;
                        end else begin
                            c_d.tcnt = c_q.tcnt + 1'b1;
                        end
                    end
                end
                ST_SMP_B: begin
                    if (tick) begin
                        if (c_q.tcnt == stage2_last) begin
                            c_d.st   = ST_SEARCH;
                            c_d.tcnt = '0;
                            seed     = 1'b1;
                        end else begin
                            c_d.tcnt = c_q.tcnt + 1'b1;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (tick) begin
                        step = 1'b1;
                        if (last_bit) begin
                            c_d.st     = ST_IDLE;
                            c_d.done   = 1'b1;
                            c_d.result = decided;
                        end
                    end
                end
                default: c_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy_o     = (c_q.st != ST_IDLE);
    assign sample_o   = (c_q.st == ST_SMP_A) || (c_q.st == ST_SMP_B);
    assign done_o     = c_q.done;
    assign result_o   = c_q.result;
    assign dac_code_o = (c_q.st == ST_SEARCH) ? (c_q.res8 ? (code << SHIFT) : code) : '0;
endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk #(
    parameter int MAX_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                abort_i,
    input logic                busy_o,
    input logic                sample_o,
    input logic                done_o,
    input logic [MAX_BITS-1:0] dac_code_o,
    input logic [MAX_BITS-1:0] result_o
);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R2
    sample_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> busy_o);

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !done_o));

    // R3
    dac_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o || sample_o) |-> (dac_code_o == '0));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
endmodule

bind sar_conv_ctrl sar_conv_chk #(.MAX_BITS(MAX_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort_i    (abort_i),
    .busy_o     (busy_o),
    .sample_o   (sample_o),
    .done_o     (done_o),
    .dac_code_o (dac_code_o),
    .result_o   (result_o)
);

// File: tb/sim_sar_conv_ctrl.sv
`timescale 1ns/1ps
module sim_sar_conv_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       abort_i = 1'b0;
    logic       res8_i = 1'b0;
    logic [1:0] smp_sel_i = 2'd0;
    logic [4:0] prs_i = 5'd0;
    logic       cmp_i;
    logic [9:0] dac_code_o;
    logic       sample_o, busy_o, done_o;
    logic [9:0] result_o;

    int  vin = 0;
    bit  junk_en = 1'b0;
    bit  junk = 1'b0;
    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  finished = 1'b0;

    // reference model state
    bit m_busy = 0, m_done = 0, m_res8 = 0;
    int m_e = 0, m_D = 2, m_S = 4, m_N = 10, m_T = 14, m_code = 0, m_result = 0;

    always #2.5 clk = ~clk;

    sar_conv_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .res8_i(res8_i), .smp_sel_i(smp_sel_i), .prs_i(prs_i), .cmp_i(cmp_i),
        .dac_code_o(dac_code_o), .sample_o(sample_o), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o)
    );

    // ideal comparator in search, noise elsewhere (R12)
    always_comb begin
        if (!busy_o || sample_o) cmp_i = junk_en ? junk : 1'b0;
        else                     cmp_i = (int'(dac_code_o) > vin);
    end

    always @(posedge clk) begin
        cyc++;
        junk = ~junk;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_result = 0; m_e = 0;
        end else begin
            m_done = 0;
            if (abort_i) begin
                m_busy = 0;
            end else if (m_busy) begin
                m_e++;
                if (m_e == m_T * m_D) begin
                    m_busy = 0; m_done = 1; m_result = m_code;
                end
            end else if (start_i) begin
                m_busy = 1; m_e = 0; m_res8 = res8_i;
                m_D = 2 * (int'(prs_i) + 1);
                m_S = 2 + (2 << smp_sel_i);
                m_N = res8_i ? 8 : 10;
                m_T = m_S + m_N;
                m_code = res8_i ? (vin >> 2) : vin;
            end
        end
    end

    function automatic int exp_dac();
        int k, j, sh, v;
        if (!m_busy) return 0;
        k = m_e / m_D;
        if (k < m_S) return 0;
        j  = k - m_S;
        sh = m_N - j;
        v  = ((m_code >> sh) << sh) | (1 << (m_N - 1 - j));
        return m_res8 ? (v << 2) : v;
    endfunction

    function automatic bit exp_sample();
        return m_busy && ((m_e / m_D) < m_S);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R8", "busy_o", int'(busy_o), int'(m_busy));
            chk("R2", "sample_o", int'(sample_o), int'(exp_sample()));
            chk("R7", "done_o", int'(done_o), int'(m_done));
            chk("R5", "result_o", int'(result_o), m_result);
            if (m_busy && !exp_sample())
                chk("R4", "dac_code_o", int'(dac_code_o), exp_dac());
            else
                chk("R3", "dac_code_o", int'(dac_code_o), 0);
        end
    end

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_model_done();
        for (int i = 0; i < 5000 && !m_done; i++) @(negedge clk);
    endtask

    task automatic run_conv(input int v, input bit r8, input int sel, input int prs, input string tag);
        @(negedge clk);
        vin = v; res8_i = r8; smp_sel_i = 2'(sel); prs_i = 5'(prs);
        pulse_start();
        wait_model_done();
        chk(tag, "done at predicted cycle", int'(done_o), 1);
        chk(tag, "final code", int'(result_o), r8 ? (v >> 2) : v);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7", "reset result", int'(result_o), 0);
        chk("R8", "reset busy", int'(busy_o), 0);

        run_conv(677, 1'b0, 0, 0, "R5");
        run_conv(1023, 1'b0, 3, 2, "R1");
        run_conv(0, 1'b0, 1, 0, "R5");
        run_conv(1023, 1'b1, 0, 1, "R6");
        run_conv(499, 1'b1, 2, 0, "R6");
        chk("R6", "upper bits zero", int'(result_o[9:8]), 0);
        run_conv(512, 1'b0, 3, 31, "R1");

        junk_en = 1'b1;
        run_conv(341, 1'b0, 1, 1, "R12");
        run_conv(170, 1'b1, 3, 0, "R12");
        junk_en = 1'b0;

        // R11: settings changed right after start
        @(negedge clk);
        vin = 300; res8_i = 1'b0; smp_sel_i = 2'd0; prs_i = 5'd1;
        pulse_start();
        res8_i = 1'b1; smp_sel_i = 2'd3; prs_i = 5'd9;
        wait_model_done();
        chk("R11", "done with captured timing", int'(done_o), 1);
        chk("R11", "captured resolution", int'(result_o), 300);

        // R10: extra start while busy
        @(negedge clk);
        vin = 777; res8_i = 1'b0; smp_sel_i = 2'd1; prs_i = 5'd0;
        pulse_start();
        repeat (6) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        wait_model_done();
        chk("R10", "done unaffected", int'(done_o), 1);
        chk("R10", "result unaffected", int'(result_o), 777);
        @(negedge clk);

        // R9: abort mid-search
        vin = 100; prs_i = 5'd0; smp_sel_i = 2'd0;
        pulse_start();
        repeat (10) @(negedge clk);
        abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
        chk("R9", "busy after abort", int'(busy_o), 0);
        chk("R9", "result kept", int'(result_o), 777);
        repeat (40) @(negedge clk);
        chk("R9", "no late done", int'(result_o), 777);
        // R9: abort beats start
        start_i = 1'b1; abort_i = 1'b1; @(negedge clk);
        start_i = 1'b0; abort_i = 1'b0;
        chk("R9", "abort beats start", int'(busy_o), 0);
        run_conv(1, 1'b0, 0, 0, "R9");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule